// File: doc/BRIEF.md
# Register Readiness Scoreboard with Wakeup

This block keeps one readiness flag for every physical register of an out-of-order core, and a small window of waiting instructions that each name up to two source registers. The physical register count is the integer register count plus the floating-point register count. When an instruction is dispatched into a window slot, the block checks each of its source registers. It also marks the instruction's destination register as not yet produced.

When a completion names a finished instruction's destination register, the block sets that register's flag. In the same clock edge it marks every waiting operand that names the register as ready. For each window slot the block reports whether the slot holds an instruction whose operands are all ready. An external allocator chooses the slots and frees them with a release strobe.

A source that rename sent as not ready is checked again against the live flags at dispatch. Register indices at or above the physical register count are not tracked.

Top module: `sb_wakeup_top`

## Requirements
- R1: After reset every register flag reads 0 (not ready), and every window slot reads invalid and not ready.
- R2: The tracked register count is INT_REGS + FP_REGS. Any index at or above it is untracked. An untracked source counts as ready at dispatch. An untracked destination changes no flag. An untracked completion changes no flag.
- R3: A dispatch with a valid tracked destination clears that register's flag. The cleared flag is visible after the clock edge that takes the dispatch.
- R4: A dispatched source is recorded ready if its rename ready flag is 1, or if the scoreboard flag of its register is already 1 at dispatch.
- R5: A completion on a tracked register sets its flag. At the same edge it marks ready every waiting operand, in any valid slot, whose tag equals that register.
- R6: When a completion and a dispatch source name the same tracked register in one cycle, the completion is applied first and the source is recorded ready.
- R7: When a completion and a dispatch destination name the same tracked register in one cycle, the register's flag ends cleared.
- R8: A slot's ready output is 1 only when the slot is valid and both of its operands are ready.
- R9: A release strobe makes the named slot invalid on the next edge. A dispatch into the same slot in the same cycle takes priority over the release.
- R10: A source that names the same register as its own instruction's destination is judged on the flag value before that dispatch clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch an instruction this cycle |
| disp_slot | input | SLOT_W | Window slot that receives it |
| disp_src_a | input | TAG_W | First source register index |
| disp_src_b | input | TAG_W | Second source register index |
| disp_rdy_a | input | 1 | Rename says first source is ready |
| disp_rdy_b | input | 1 | Rename says second source is ready |
| disp_dst_valid | input | 1 | Instruction writes a destination |
| disp_dst | input | TAG_W | Destination register index |
| cmpl_valid | input | 1 | A completion is reported this cycle |
| cmpl_dst | input | TAG_W | Destination register of the finished instruction |
| rel_valid | input | 1 | Release a window slot |
| rel_slot | input | SLOT_W | Slot to release |
| entry_valid_o | output | WIN | Per-slot occupied flag |
| entry_ready_o | output | WIN | Per-slot all-operands-ready flag |
| sb_bits_o | output | PREGS | Per-register readiness flags |

## Verification
The bench builds the block with four integer and four floating-point registers, 4-bit tags and a four-slot window. This configuration gives eight tracked registers and eight untracked indices. With so few registers and slots, random traffic often produces the rare collisions. These include a completion meeting a dispatch source or destination on the same register, a release meeting a dispatch on the same slot, and a wakeup reaching several slots at once. The full flag vector and both window vectors are compared every cycle against arithmetic expectations, first over directed cases for each corner and then over a long random sweep.

// File: rtl/sb_pkg.sv
package sb_pkg;
    // Source operands carried by each waiting instruction
    localparam int unsigned SB_NSRC = 2;
endpackage

// File: rtl/sb_reg_flags.sv
module sb_reg_flags
    import sb_pkg::*;
#(
    parameter int unsigned PREGS = 128,
    parameter int unsigned TAG_W = 8,
    parameter int unsigned NRD   = SB_NSRC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_valid,
    input  logic [TAG_W-1:0]           set_tag,
    input  logic                       clr_valid,
    input  logic [TAG_W-1:0]           clr_tag,
    input  logic [NRD-1:0][TAG_W-1:0]  rd_tag,
    output logic [NRD-1:0]             rd_ready,
    output logic [PREGS-1:0]           bits_o
);
    localparam int unsigned IDX_W = (PREGS > 1) ? $clog2(PREGS) : 1;

    typedef struct packed {
        logic [PREGS-1:0] bits;
    } flags_t;

    flags_t st_d, st_q;

    function automatic logic tracked(input logic [TAG_W-1:0] t);
        return ({1'b0, t} < (TAG_W+1)'(PREGS));
    endfunction

    logic set_hit;
    assign set_hit = set_valid && tracked(set_tag);

    // completion is applied first, then the dispatch clear
    always_comb begin
        st_d = st_q;
        if (set_hit)
            st_d.bits[set_tag[IDX_W-1:0]] = 1'b1;
        if (clr_valid && tracked(clr_tag))
            st_d.bits[clr_tag[IDX_W-1:0]] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read view: registered flag or a completion on the same register now
    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            always_comb begin
                rd_ready[r] = 1'b0;
                if (tracked(rd_tag[r]))
                    rd_ready[r] = st_q.bits[rd_tag[r][IDX_W-1:0]]
                                  || (set_hit && (set_tag == rd_tag[r]));
            end
        end
    endgenerate

    assign bits_o = st_q.bits;
endmodule

// File: rtl/sb_wait_slot.sv
module sb_wait_slot
    import sb_pkg::*;
#(
    parameter int unsigned TAG_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [SB_NSRC-1:0][TAG_W-1:0] load_tag,
    input  logic [SB_NSRC-1:0]            load_rdy,
    input  logic                          wake_valid,
    input  logic [TAG_W-1:0]              wake_tag,
    input  logic                          free,
    output logic                          valid_o,
    output logic                          ready_o
);
    typedef struct packed {
        logic                          valid;
        logic [SB_NSRC-1:0]            rdy;
        logic [SB_NSRC-1:0][TAG_W-1:0] tag;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.tag   = load_tag;
            st_d.rdy   = load_rdy;
        end else begin
            if (free)
                st_d.valid = 1'b0;
            for (int k = 0; k < SB_NSRC; k++)
                if (wake_valid && (st_q.tag[k] == wake_tag))
                    st_d.rdy[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign ready_o = st_q.valid && (&st_q.rdy);
endmodule

// File: rtl/sb_wakeup_top.sv
module sb_wakeup_top
    import sb_pkg::*;
#(
    parameter  int unsigned INT_REGS = 64,
    parameter  int unsigned FP_REGS  = 64,
    parameter  int unsigned TAG_W    = 8,
    parameter  int unsigned WIN      = 8,
    localparam int unsigned PREGS    = INT_REGS + FP_REGS,
    localparam int unsigned SLOT_W   = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [SLOT_W-1:0] disp_slot,
    input  logic [TAG_W-1:0]  disp_src_a,
    input  logic [TAG_W-1:0]  disp_src_b,
    input  logic              disp_rdy_a,
    input  logic              disp_rdy_b,
    input  logic              disp_dst_valid,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              cmpl_valid,
    input  logic [TAG_W-1:0]  cmpl_dst,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [WIN-1:0]    entry_valid_o,
    output logic [WIN-1:0]    entry_ready_o,
    output logic [PREGS-1:0]  sb_bits_o
);
    function automatic logic tracked(input logic [TAG_W-1:0] t);
        return ({1'b0, t} < (TAG_W+1)'(PREGS));
    endfunction

    logic [SB_NSRC-1:0][TAG_W-1:0] src_tag;
    logic [SB_NSRC-1:0]            src_hint;
    logic [SB_NSRC-1:0]            src_live;
    logic [SB_NSRC-1:0]            src_rdy;
    logic                          wake_ok;

    assign src_tag  = {disp_src_b, disp_src_a};
    assign src_hint = {disp_rdy_b, disp_rdy_a};
    assign wake_ok  = cmpl_valid && tracked(cmpl_dst);

    sb_reg_flags #(
        .PREGS (PREGS),
        .TAG_W (TAG_W),
        .NRD   (SB_NSRC)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (cmpl_valid),
        .set_tag   (cmpl_dst),
        .clr_valid (disp_valid && disp_dst_valid),
        .clr_tag   (disp_dst),
        .rd_tag    (src_tag),
        .rd_ready  (src_live),
        .bits_o    (sb_bits_o)
    );

    // rename hint, untracked index or live flag all make a source ready
    always_comb begin
        for (int k = 0; k < SB_NSRC; k++)
            src_rdy[k] = src_hint[k] || !tracked(src_tag[k]) || src_live[k];
    end

    generate
        for (genvar e = 0; e < WIN; e++) begin : g_slot
            sb_wait_slot #(
                .TAG_W (TAG_W)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (disp_valid && (disp_slot == SLOT_W'(e))),
                .load_tag   (src_tag),
                .load_rdy   (src_rdy),
                .wake_valid (wake_ok),
                .wake_tag   (cmpl_dst),
                .free       (rel_valid && (rel_slot == SLOT_W'(e))),
                .valid_o    (entry_valid_o[e]),
                .ready_o    (entry_ready_o[e])
            );
        end
    endgenerate
endmodule

// File: rtl/sb_wakeup_chk.sv
module sb_wakeup_chk #(
    parameter  int unsigned INT_REGS = 64,
    parameter  int unsigned FP_REGS  = 64,
    parameter  int unsigned TAG_W    = 8,
    parameter  int unsigned WIN      = 8,
    localparam int unsigned PREGS    = INT_REGS + FP_REGS,
    localparam int unsigned SLOT_W   = (WIN > 1) ? $clog2(WIN) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic [SLOT_W-1:0] disp_slot,
    input logic [TAG_W-1:0]  disp_src_a,
    input logic [TAG_W-1:0]  disp_src_b,
    input logic              disp_rdy_a,
    input logic              disp_rdy_b,
    input logic              disp_dst_valid,
    input logic [TAG_W-1:0]  disp_dst,
    input logic              cmpl_valid,
    input logic [TAG_W-1:0]  cmpl_dst,
    input logic              rel_valid,
    input logic [SLOT_W-1:0] rel_slot,
    input logic [WIN-1:0]    entry_valid_o,
    input logic [WIN-1:0]    entry_ready_o,
    input logic [PREGS-1:0]  sb_bits_o
);
    localparam int unsigned IDX_W = (PREGS > 1) ? $clog2(PREGS) : 1;

    function automatic logic tracked(input logic [TAG_W-1:0] t);
        return ({1'b0, t} < (TAG_W+1)'(PREGS));
    endfunction

    logic dst_clr;
    assign dst_clr = disp_valid && disp_dst_valid;

    assert_cmpl_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && tracked(cmpl_dst) && !(dst_clr && (disp_dst == cmpl_dst)))
        |=> sb_bits_o[$past(cmpl_dst[IDX_W-1:0])]);

    assert_disp_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_clr && tracked(disp_dst))
        |=> !sb_bits_o[$past(disp_dst[IDX_W-1:0])]);

    assert_untracked_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !tracked(disp_src_a) && !tracked(disp_src_b))
        |=> entry_ready_o[$past(disp_slot)]);

    assert_untracked_cmpl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && !tracked(cmpl_dst) && !dst_clr)
        |=> $stable(sb_bits_o));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !(disp_valid && (disp_slot == rel_slot)))
        |=> !entry_valid_o[$past(rel_slot)]);
endmodule

bind sb_wakeup_top sb_wakeup_chk #(
    .INT_REGS (INT_REGS),
    .FP_REGS  (FP_REGS),
    .TAG_W    (TAG_W),
    .WIN      (WIN)
) u_chk (.*);

// File: tb/tb_sb_wakeup_top.sv
module tb_sb_wakeup_top;
    localparam int unsigned INT_REGS = 4;
    localparam int unsigned FP_REGS  = 4;
    localparam int unsigned TAG_W    = 4;
    localparam int unsigned WIN      = 4;
    localparam int unsigned PREGS    = INT_REGS + FP_REGS;
    localparam int unsigned SLOT_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              disp_valid, disp_rdy_a, disp_rdy_b, disp_dst_valid;
    logic [SLOT_W-1:0] disp_slot, rel_slot;
    logic [TAG_W-1:0]  disp_src_a, disp_src_b, disp_dst, cmpl_dst;
    logic              cmpl_valid, rel_valid;
    logic [WIN-1:0]    entry_valid_o, entry_ready_o;
    logic [PREGS-1:0]  sb_bits_o;

    always #5 clk = ~clk;

    sb_wakeup_top #(
        .INT_REGS (INT_REGS),
        .FP_REGS  (FP_REGS),
        .TAG_W    (TAG_W),
        .WIN      (WIN)
    ) dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected state
    logic [PREGS-1:0] e_sb;
    logic [WIN-1:0]   e_v;
    logic [1:0]       e_r [WIN];
    logic [TAG_W-1:0] e_t [WIN][2];

    function automatic bit trk(input logic [TAG_W-1:0] t);
        return int'(t) < int'(PREGS);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = 0; disp_slot = '0; disp_src_a = '0; disp_src_b = '0;
        disp_rdy_a = 0; disp_rdy_b = 0; disp_dst_valid = 0; disp_dst = '0;
        cmpl_valid = 0; cmpl_dst = '0; rel_valid = 0; rel_slot = '0;
    endtask

    function automatic logic [WIN-1:0] exp_ready();
        logic [WIN-1:0] r;
        for (int e = 0; e < WIN; e++) r[e] = e_v[e] & e_r[e][0] & e_r[e][1];
        return r;
    endfunction

    // compute next expected state from inputs, clock it, compare at negedge
    task automatic tick(input string req);
        logic [PREGS-1:0] n_sb;
        logic [WIN-1:0]   n_v;
        logic [1:0]       n_r [WIN];
        logic [TAG_W-1:0] n_t [WIN][2];
        logic [1:0]       srdy;
        logic [TAG_W-1:0] st [2];
        bit               cw;
        cw = cmpl_valid && trk(cmpl_dst);
        n_sb = e_sb; n_v = e_v;
        for (int e = 0; e < WIN; e++) begin
            n_r[e] = e_r[e]; n_t[e][0] = e_t[e][0]; n_t[e][1] = e_t[e][1];
        end
        st[0] = disp_src_a; st[1] = disp_src_b;
        srdy = {disp_rdy_b, disp_rdy_a};
        for (int k = 0; k < 2; k++)
            if (!trk(st[k]) || e_sb[int'(st[k])] || (cw && cmpl_dst == st[k]))
                srdy[k] = 1'b1;
        if (cw) n_sb[int'(cmpl_dst)] = 1'b1;
        if (disp_valid && disp_dst_valid && trk(disp_dst))
            n_sb[int'(disp_dst)] = 1'b0;
        for (int e = 0; e < WIN; e++) begin
            if (disp_valid && int'(disp_slot) == e) begin
                n_v[e] = 1'b1; n_r[e] = srdy;
                n_t[e][0] = st[0]; n_t[e][1] = st[1];
            end else begin
                if (rel_valid && int'(rel_slot) == e) n_v[e] = 1'b0;
                for (int k = 0; k < 2; k++)
                    if (cw && e_t[e][k] == cmpl_dst) n_r[e][k] = 1'b1;
            end
        end
        @(posedge clk);
        e_sb = n_sb; e_v = n_v;
        for (int e = 0; e < WIN; e++) begin
            e_r[e] = n_r[e]; e_t[e][0] = n_t[e][0]; e_t[e][1] = n_t[e][1];
        end
        @(negedge clk);
        check(sb_bits_o == e_sb, req, "flags", 32'(sb_bits_o), 32'(e_sb));
        check(entry_valid_o == e_v, req, "valid", 32'(entry_valid_o), 32'(e_v));
        check(entry_ready_o == exp_ready(), req, "ready",
              32'(entry_ready_o), 32'(exp_ready()));
        idle();
    endtask

    task automatic disp(input int slot, input int a, input int b,
                        input bit ra, input bit rb, input bit dv, input int d);
        disp_valid = 1; disp_slot = SLOT_W'(slot);
        disp_src_a = TAG_W'(a); disp_src_b = TAG_W'(b);
        disp_rdy_a = ra; disp_rdy_b = rb; disp_dst_valid = dv; disp_dst = TAG_W'(d);
    endtask

    task automatic cmpl(input int d);
        cmpl_valid = 1; cmpl_dst = TAG_W'(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        e_sb = '0; e_v = '0;
        for (int e = 0; e < WIN; e++) begin
            e_r[e] = '0; e_t[e][0] = '0; e_t[e][1] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(sb_bits_o == '0, "R1", "flags", 32'(sb_bits_o), 0);
        check(entry_valid_o == '0, "R1", "valid", 32'(entry_valid_o), 0);
        check(entry_ready_o == '0, "R1", "ready", 32'(entry_ready_o), 0);

        // R2 untracked sources ready, untracked dst/completion ignored
        disp(0, 9, 12, 0, 0, 1, 10); tick("R2");
        cmpl(11); tick("R2");
        // R4 waiting sources; R5 wakeup of one operand
        disp(1, 2, 3, 0, 0, 0, 0); tick("R4");
        cmpl(2); tick("R5");
        // R6 completion meets dispatch source on reg 3
        disp(2, 3, 12, 0, 0, 0, 0); cmpl(3); tick("R6");
        // R4 re-check against live flag
        disp(3, 3, 3, 0, 0, 0, 0); tick("R4");
        // R3 clear destination
        disp(3, 1, 1, 1, 1, 1, 3); tick("R3");
        // R7 completion and dispatch destination on same reg
        disp(2, 0, 0, 1, 1, 1, 2); cmpl(2); tick("R7");
        // R10 source equals own destination
        cmpl(5); tick("R5");
        disp(1, 5, 6, 0, 1, 1, 5); tick("R10");
        // R8 one operand waiting keeps slot not ready
        disp(0, 7, 9, 0, 0, 0, 0); tick("R8");
        cmpl(7); tick("R8");
        // R9 release, then release colliding with dispatch
        rel_valid = 1; rel_slot = 2; tick("R9");
        rel_valid = 1; rel_slot = 1; disp(1, 4, 4, 0, 0, 0, 0); tick("R9");
        // wakeup reaching several slots at once
        disp(2, 4, 12, 0, 0, 0, 0); tick("R5");
        cmpl(4); tick("R5");

        // random sweep
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 2) != 0)
                disp(int'($urandom_range(0, WIN-1)), int'($urandom_range(0, 15)),
                     int'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0),
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1),
                     int'($urandom_range(0, 15)));
            if ($urandom_range(0, 1) == 1) cmpl(int'($urandom_range(0, 15)));
            if ($urandom_range(0, 3) == 0) begin
                rel_valid = 1; rel_slot = SLOT_W'($urandom_range(0, WIN-1));
            end
            tick("R3 R4 R5 R6 R7 R9 sweep");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule